// File: doc/BRIEF.md
# Serial Delay-Code Register Slave

This block is a four-wire serial slave that keeps three 6-bit skew-compensation delay codes, one each for the red, green and blue video paths. Their values drive the delay-selection logic downstream as parallel outputs. A host sets or reads back one code per transaction. Each transaction is a fixed 16-bit frame. It begins when chip select falls and ends when chip select rises. The first byte is a command and the second byte carries the code.

The block runs in the system clock domain. Chip select, serial clock and serial data are taken as already synchronous to that clock, and the rising edges of the serial clock are found by edge detection. A serial clock half-period of at least two system clocks is assumed. An enable input gates the whole port, so that it reacts only while digital serial control is selected.

Top module: `dlyspi_top`

## Requirements
- R1: After a synchronous reset, all three codes read 0 and `sdo` is low.
- R2: Bits move MSB first and are sampled on rising `sck` edges while `cs_n` is low. Command byte layout: bit 7 is the direction (0 = write, 1 = read), bits 6..2 must be zero, and bits 1..0 select the channel (00 red, 01 green, 10 blue). In the data byte, bits 5..0 are the code and bits 7..6 are ignored. A legal write changes only the selected code, and it does so within two system clocks after the sixteenth rising edge.
- R3: On a legal read, after rising edges 10 to 15 of the frame, `sdo` carries the selected code bits 5 down to 0 in turn. A read changes no code.
- R4: `sdo` stays low through the first nine edges of any frame, through whole write frames, after the sixteenth edge, and whenever `cs_n` is high.
- R5: If `cs_n` rises before the sixteenth edge, the frame is dropped and no code changes.
- R6: A channel selector of 11, or any nonzero reserved bit, turns a write into a no-op and makes a read return all zeros.
- R7: While `spi_en` is low, frames are ignored: no code changes and `sdo` stays low.
- R8: Rising edges after the sixteenth one in a frame are ignored, and a frame commits at most once.
- R9: `codes_o` packs red in bits 5..0, green in bits 11..6 and blue in bits 17..12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_en | input | 1 | Serial control selected; port ignores frames when low |
| cs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial readback data to host |
| codes_o | output | 18 | Three packed 6-bit delay codes |

## Verification
A bit counter that is wrong by one shows up within a single frame. A written code lands doubled or halved on `codes_o`, and the readback on `sdo` is shifted by one position. A fault in command decoding puts a write on the wrong channel or lets an illegal command through. This becomes visible on the packed outputs two system clocks after the sixteenth edge. If the abort or enable gating is lost, a code changes after a truncated frame or a disabled frame, and the next read exposes it.

// File: rtl/dlyspi_pkg.sv
package dlyspi_pkg;
  localparam int CODE_W     = 6;
  localparam int N_CH       = 3;
  localparam int FRAME_BITS = 16;
  localparam int CMD_BITS   = 8;
  localparam int SEL_W      = 2;

  typedef enum logic [SEL_W-1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2,
    CH_NONE  = 2'd3
  } chan_e;
endpackage

// File: rtl/dlyspi_rx.sv
module dlyspi_rx #(
  parameter int FRAME_BITS = 16,
  parameter int CMD_BITS   = 8,
  parameter int CODE_W     = 6,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                cs_n,
  input  logic                sck,
  input  logic                sdi,
  output logic                active,
  output logic                rise,
  output logic [CNT_W-1:0]    cnt,
  output logic [CMD_BITS-1:0] cmd,
  output logic                cmd_vld,
  output logic                frame_done,
  output logic [CODE_W-1:0]   payload
);
  localparam int SH_W = CMD_BITS - 1;
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_END  = CNT_W'(FRAME_BITS);

  logic            sck_q;
  logic [SH_W-1:0] shreg;

  assign active = en & ~cs_n;
  assign rise   = active & sck & ~sck_q;

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck;
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt        <= '0;
      shreg      <= '0;
      cmd_vld    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (rise && cnt < FRAME_END) begin
        shreg <= {shreg[SH_W-2:0], sdi};
        cnt   <= cnt + 1'b1;
        if (cnt == CMD_LAST) cmd_vld <= 1'b1;
        if (cnt == FRAME_LAST) frame_done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd     <= '0;
      payload <= '0;
    end else if (rise) begin
      if (cnt == CMD_LAST)   cmd     <= {shreg, sdi};
      if (cnt == FRAME_LAST) payload <= {shreg[CODE_W-2:0], sdi};
    end
  end
endmodule

// File: rtl/dlyspi_regs.sv
module dlyspi_regs #(
  parameter int N_CH   = 3,
  parameter int CODE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_CH-1:0]          wr_en,
  input  logic [CODE_W-1:0]        wr_data,
  output logic [N_CH*CODE_W-1:0]   codes
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)           codes[i*CODE_W +: CODE_W] <= '0;
      else if (wr_en[i]) codes[i*CODE_W +: CODE_W] <= wr_data;
    end
  end
endmodule

// File: rtl/dlyspi_tx.sv
module dlyspi_tx #(
  parameter int FRAME_BITS = 16,
  parameter int CODE_W     = 6,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              rise,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              rd_en,
  input  logic [CODE_W-1:0] rd_code,
  output logic              sdo
);
  localparam logic [CNT_W-1:0] WIN_FIRST = CNT_W'(FRAME_BITS - CODE_W - 1);
  localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(FRAME_BITS - 2);

  logic [CODE_W-1:0] sh;
  logic              in_win;

  assign in_win = rd_en && cnt >= WIN_FIRST && cnt <= WIN_LAST;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      sdo <= 1'b0;
      sh  <= '0;
    end else if (rise) begin
      if (!in_win) begin
        sdo <= 1'b0;
        sh  <= '0;
      end else if (cnt == WIN_FIRST) begin
        sdo <= rd_code[CODE_W-1];
        sh  <= {rd_code[CODE_W-2:0], 1'b0};
      end else begin
        sdo <= sh[CODE_W-1];
        sh  <= {sh[CODE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/dlyspi_top.sv
module dlyspi_top
  import dlyspi_pkg::*;
#(
  parameter int P_CODE_W = CODE_W,
  parameter int P_N_CH   = N_CH
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         spi_en,
  input  logic                         cs_n,
  input  logic                         sck,
  input  logic                         sdi,
  output logic                         sdo,
  output logic [P_N_CH*P_CODE_W-1:0]   codes_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic                active, rise, cmd_vld, frame_done;
  logic [CNT_W-1:0]    cnt;
  logic [CMD_BITS-1:0] cmd;
  logic [P_CODE_W-1:0] payload;
  logic                rw, legal, rd_en;
  logic [SEL_W-1:0]    sel;
  logic [P_N_CH-1:0]   wr_en;
  logic [P_CODE_W-1:0] rd_code;

  dlyspi_rx #(
    .FRAME_BITS(FRAME_BITS), .CMD_BITS(CMD_BITS), .CODE_W(P_CODE_W), .CNT_W(CNT_W)
  ) u_rx (
    .clk(clk), .rst(rst), .en(spi_en), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .active(active), .rise(rise), .cnt(cnt), .cmd(cmd), .cmd_vld(cmd_vld),
    .frame_done(frame_done), .payload(payload)
  );

  assign rw    = cmd[CMD_BITS-1];
  assign sel   = cmd[SEL_W-1:0];
  assign legal = (cmd[CMD_BITS-2:SEL_W] == '0) && (int'(sel) < P_N_CH);
  assign rd_en = cmd_vld & rw & legal;

  for (genvar i = 0; i < P_N_CH; i++) begin : g_wr
    assign wr_en[i] = frame_done & ~rw & legal & (sel == SEL_W'(i));
  end

  always_comb begin
    rd_code = '0;
    for (int i = 0; i < P_N_CH; i++)
      if (legal && sel == SEL_W'(i)) rd_code = codes_o[i*P_CODE_W +: P_CODE_W];
  end

  dlyspi_regs #(.N_CH(P_N_CH), .CODE_W(P_CODE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(payload), .codes(codes_o)
  );

  dlyspi_tx #(.FRAME_BITS(FRAME_BITS), .CODE_W(P_CODE_W), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .active(active), .rise(rise), .cnt(cnt),
    .rd_en(rd_en), .rd_code(rd_code), .sdo(sdo)
  );
endmodule

// File: rtl/dlyspi_chk.sv
module dlyspi_chk #(
  parameter int N_CH       = 3,
  parameter int CODE_W     = 6,
  parameter int FRAME_BITS = 16,
  parameter int CNT_W      = 5
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   spi_en,
  input logic                   cs_n,
  input logic                   sdo,
  input logic [N_CH*CODE_W-1:0] codes_o,
  input logic                   frame_done,
  input logic [N_CH-1:0]        wr_en,
  input logic [CNT_W-1:0]       cnt,
  input logic                   legal,
  input logic                   rw
);
  localparam logic [CNT_W-1:0] QUIET_LAST = CNT_W'(FRAME_BITS - CODE_W - 2);

  assert_idle_sdo_R7: assert property (@(posedge clk) disable iff (rst)
    (cs_n || !spi_en) |=> !sdo);

  assert_first_byte_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt <= QUIET_LAST) |=> !sdo);

  assert_commit_only_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(codes_o) |-> $past(frame_done));

  assert_illegal_noop_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !legal) |=> $stable(codes_o));

  assert_read_noop_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_done && rw) |=> $stable(codes_o));

  assert_single_target_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

  assert_single_commit_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
endmodule

bind dlyspi_top dlyspi_chk #(
  .N_CH(P_N_CH), .CODE_W(P_CODE_W), .FRAME_BITS(dlyspi_pkg::FRAME_BITS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .spi_en(spi_en), .cs_n(cs_n), .sdo(sdo), .codes_o(codes_o),
  .frame_done(frame_done), .wr_en(wr_en), .cnt(cnt), .legal(legal), .rw(rw)
);

// File: tb/sim_dlyspi_top.sv
module sim_dlyspi_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int NVEC       = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_en = 1'b1;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo;
  logic [17:0] codes_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dlyspi_top u0 (
    .clk(clk), .rst(rst), .spi_en(spi_en), .cs_n(cs_n),
    .sck(sck), .sdi(sdi), .sdo(sdo), .codes_o(codes_o)
  );

  // {cmd, data, exp red, exp green, exp blue, exp readback}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h01, 8'h2A, 6'd0, 6'd42, 6'd0,  6'd0},   // R2 write green 42
    {8'h00, 8'hC5, 6'd5, 6'd42, 6'd0,  6'd0},   // R2 bits 7..6 ignored
    {8'h02, 8'h3F, 6'd5, 6'd42, 6'd63, 6'd0},   // R2 write blue 63
    {8'h82, 8'h00, 6'd5, 6'd42, 6'd63, 6'd63},  // R3 read blue
    {8'h81, 8'hFF, 6'd5, 6'd42, 6'd63, 6'd42},  // R3 read green
    {8'h80, 8'h00, 6'd5, 6'd42, 6'd63, 6'd5},   // R3 read red
    {8'h03, 8'h11, 6'd5, 6'd42, 6'd63, 6'd0},   // R6 write selector 11
    {8'h83, 8'h00, 6'd5, 6'd42, 6'd63, 6'd0},   // R6 read selector 11
    {8'h21, 8'h07, 6'd5, 6'd42, 6'd63, 6'd0},   // R6 reserved bit in write
    {8'hA0, 8'h00, 6'd5, 6'd42, 6'd63, 6'd0},   // R6 reserved bit in read
    {8'h02, 8'h00, 6'd5, 6'd42, 6'd0,  6'd0},   // R2 write blue 0
    {8'h82, 8'h00, 6'd5, 6'd42, 6'd0,  6'd0}    // R3 read blue 0
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [23:0] bits, input int nbits,
                           output logic [5:0] rd, output logic stray);
    rd = '0;
    stray = 1'b0;
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int j = 1; j <= nbits; j++) begin
      sdi = bits[24-j];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (j >= 10 && j <= 15) rd[15-j] = sdo;
      else if (sdo) stray = 1'b1;
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    if (sdo) stray = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] rd;
    logic       stray;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 codes after reset", 32'(codes_o), 32'h0);
    check("R1 sdo after reset", 32'(sdo), 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      run_frame({VEC[v][39:24], 8'hFF}, 16, rd, stray);
      check("R2 R9 packed codes", 32'(codes_o),
            32'({VEC[v][11:6], VEC[v][17:12], VEC[v][23:18]}));
      check("R3 readback", 32'(rd), 32'(VEC[v][5:0]));
      check("R4 sdo low outside window", 32'(stray), 32'h0);
    end

    // R5: abort after 12 and after 15 edges
    run_frame({8'h00, 8'h3F, 8'hFF}, 12, rd, stray);
    check("R5 abort at 12", 32'(codes_o[5:0]), 32'd5);
    run_frame({8'h00, 8'h3F, 8'hFF}, 15, rd, stray);
    check("R5 abort at 15", 32'(codes_o[5:0]), 32'd5);

    // R7: disabled port
    spi_en = 1'b0;
    run_frame({8'h00, 8'h21, 8'hFF}, 16, rd, stray);
    check("R7 write ignored", 32'(codes_o), 32'({6'd0, 6'd42, 6'd5}));
    run_frame({8'h80, 8'h00, 8'hFF}, 16, rd, stray);
    check("R7 read gives zero", 32'(rd), 32'h0);
    check("R7 sdo low", 32'(stray), 32'h0);
    spi_en = 1'b1;

    // R8: extra edges beyond sixteen
    run_frame({8'h01, 8'h15, 8'hFF}, 20, rd, stray);
    check("R8 extra edges ignored", 32'(codes_o[11:6]), 32'd21);
    check("R8 sdo low after frame", 32'(stray), 32'h0);
    run_frame({8'h81, 8'h00, 8'hFF}, 16, rd, stray);
    check("R8 readback after long frame", 32'(rd), 32'd21);

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 codes after second reset", 32'(codes_o), 32'h0);
    run_frame({8'h82, 8'h00, 8'hFF}, 16, rd, stray);
    check("R1 readback after reset", 32'(rd), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule